// File: doc/BRIEF.md
# Banked Context Register File

This block is the general-purpose register file of a small processor core. It holds 32 registers of 32 bits and has three read ports, one write port and a hidden auxiliary register for the second result of multiply and divide. Registers 0 to 13 carry function arguments and are never saved. Registers 14 to 29 hold locals and are saved by hardware. Registers 30 and 31 are free registers that are neither saved nor used for arguments.

On a call the block copies the 16 local registers into an internal stack of frames, four registers per cycle. On a return it copies the newest frame back, also over four cycles. While a copy sequence runs, the stall output holds the pipeline. An interrupt or exception switches every register access to a second, private bank. The return from the exception switches back, so the interrupted code's argument and local registers come back untouched.

Top module: `rf_ctx_bank`

## Requirements
- R1: After reset every register in both banks and the auxiliary register read zero, and stall_o, exc_mode_o, ovf_o and unf_o are low.
- R2: The three read ports independently return the contents of the addressed register. A write with wr_en_i high while not stalled updates the addressed register at the clock edge.
- R3: When a read port addresses the register being written in the same cycle, it returns the new write data in that cycle.
- R4: aux_wr_en_i loads aux_data_i into the auxiliary register, which appears on aux_data_o from the next cycle. Both banks share the one auxiliary register.
- R5: A call accepted while idle raises stall_o for exactly the 4 cycles that follow the accepting edge. Register contents do not change during the save.
- R6: A return restores registers 14 to 29 to the values they held when the matching call was accepted, with stall_o high for 4 cycles. Registers 0 to 13, 30 and 31 keep their current values.
- R7: Calls nest up to 8 deep, and returns restore the frames in last-in, first-out order.
- R8: A call made while 8 frames are stored pulses ovf_o high for one cycle. A return made with no frame stored pulses unf_o high for one cycle. Neither starts a sequence or changes any register.
- R9: Register writes and auxiliary writes presented while stall_o is high are ignored.
- R10: An interrupt request taken while idle sets exc_mode_o from the next cycle. All reads and writes then use the exception bank. eret_i clears exc_mode_o and returns the normal bank unchanged.
- R11: An interrupt request that arrives during a save or restore is held and taken on the cycle after stall_o falls. Requests that arrive while exc_mode_o is high are dropped.
- R12: If an interrupt request and a call arrive together while idle and not in exception mode, the interrupt is taken and the call is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr0_i | input | 5 | Read port 0 address |
| rd_addr1_i | input | 5 | Read port 1 address |
| rd_addr2_i | input | 5 | Read port 2 address |
| rd_data0_o | output | 32 | Read port 0 data |
| rd_data1_o | output | 32 | Read port 1 data |
| rd_data2_o | output | 32 | Read port 2 data |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| aux_wr_en_i | input | 1 | Auxiliary register write enable |
| aux_data_i | input | 32 | Auxiliary write data |
| aux_data_o | output | 32 | Auxiliary register contents |
| call_i | input | 1 | Function call: save the local registers |
| ret_i | input | 1 | Function return: restore the local registers |
| irq_i | input | 1 | Interrupt or exception entry request |
| eret_i | input | 1 | Exception return |
| stall_o | output | 1 | High while a save or restore runs |
| exc_mode_o | output | 1 | High while the exception bank is selected |
| ovf_o | output | 1 | One-cycle pulse: call with a full stack |
| unf_o | output | 1 | One-cycle pulse: return with an empty stack |

## Verification
The functions that can coincide are interrupt entry and the multi-cycle save. The bench raises irq_i one cycle into a call's save sequence. It then checks that exc_mode_o stays low for every stalled cycle and for the cycle in which stall_o falls, and rises one cycle later. It also drives irq_i and call_i in the same idle cycle and judges the outcome at the ports: no stall, the exception bank selected, and a later return that underflows, which shows the call left no frame behind.

// File: rtl/rf_ctx_pkg.sv
`timescale 1ns/1ps
package rf_ctx_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SAVE, SQ_REST} seq_state_e;
endpackage

// File: rtl/rf_seq_ctrl.sv
`timescale 1ns/1ps
module rf_seq_ctrl
  import rf_ctx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int GROUPS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      call_i,
  input  logic                      ret_i,
  input  logic                      irq_i,
  input  logic                      eret_i,
  output logic                      busy_o,
  output logic                      save_en_o,
  output logic                      rest_en_o,
  output logic [$clog2(GROUPS)-1:0] grp_o,
  output logic [$clog2(DEPTH)-1:0]  frame_o,
  output logic                      bank_o,
  output logic                      ovf_o,
  output logic                      unf_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int GW  = $clog2(GROUPS);
  localparam int FW  = $clog2(DEPTH);

  seq_state_e     state_q;
  logic [GW-1:0]  cnt_q;
  logic [SPW-1:0] sp_q, sp_m1;
  logic           in_exc_q, irq_pend_q, ovf_q, unf_q;
  logic           idle, take_irq, do_eret, last_grp;

  assign idle     = (state_q == SQ_IDLE);
  assign take_irq = idle && !in_exc_q && (irq_i || irq_pend_q);
  assign do_eret  = idle && in_exc_q && eret_i;
  assign last_grp = (cnt_q == GW'(GROUPS - 1));
  assign sp_m1    = sp_q - SPW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      sp_q       <= '0;
      in_exc_q   <= 1'b0;
      irq_pend_q <= 1'b0;
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      // requests during a sequence wait; requests inside an ISR are dropped
      if (irq_i && !in_exc_q && !idle) irq_pend_q <= 1'b1;
      unique case (state_q)
        SQ_IDLE: begin
          if (take_irq) begin
            in_exc_q   <= 1'b1;
            irq_pend_q <= 1'b0;
          end else if (do_eret) begin
            in_exc_q <= 1'b0;
          end else if (call_i) begin
            if (sp_q == SPW'(DEPTH)) ovf_q <= 1'b1;
            else begin
              state_q <= SQ_SAVE;
              cnt_q   <= '0;
            end
          end else if (ret_i) begin
            if (sp_q == '0) unf_q <= 1'b1;
            else begin
              state_q <= SQ_REST;
              cnt_q   <= '0;
            end
          end
        end
        SQ_SAVE: begin
          cnt_q <= cnt_q + GW'(1);
          if (last_grp) begin
            state_q <= SQ_IDLE;
            sp_q    <= sp_q + SPW'(1);
          end
        end
        SQ_REST: begin
          cnt_q <= cnt_q + GW'(1);
          if (last_grp) begin
            state_q <= SQ_IDLE;
            sp_q    <= sp_m1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o    = !idle;
  assign save_en_o = (state_q == SQ_SAVE);
  assign rest_en_o = (state_q == SQ_REST);
  assign grp_o     = cnt_q;
  assign frame_o   = (state_q == SQ_REST) ? sp_m1[FW-1:0] : sp_q[FW-1:0];
  assign bank_o    = in_exc_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;

  a_r7_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SPW'(DEPTH));
  a_r8_ovf_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (sp_q == SPW'(DEPTH)) && idle);
  a_r8_unf_only_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> (sp_q == '0) && idle);
  a_r5_save_runs_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_SAVE && !last_grp) |=> state_q == SQ_SAVE);
  a_r11_bank_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable(in_exc_q));
  a_r11_no_nesting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exc_q && !eret_i) |=> in_exc_q);
endmodule

// File: rtl/rf_save_stack.sv
`timescale 1ns/1ps
module rf_save_stack #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int NCTX  = 16,
  parameter int LANES = 4
) (
  input  logic                                 clk_i,
  input  logic                                 wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]             frame_i,
  input  logic [$clog2(NCTX/LANES)-1:0]        grp_i,
  input  logic [LANES-1:0][DW-1:0]             wdata_i,
  output logic [LANES-1:0][DW-1:0]             rdata_o
);
  localparam int AW = $clog2(DEPTH * NCTX);

  logic [DW-1:0] mem_q [DEPTH*NCTX];
  logic [AW-1:0] base;

  assign base = AW'(frame_i) * AW'(NCTX) + AW'(grp_i) * AW'(LANES);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) mem_q[base + AW'(l)] <= wdata_i[l];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) rdata_o[l] = mem_q[base + AW'(l)];
  end
endmodule

// File: rtl/rf_reg_banks.sv
`timescale 1ns/1ps
module rf_reg_banks #(
  parameter int DW       = 32,
  parameter int NREG     = 32,
  parameter int CTX_BASE = 14,
  parameter int NCTX     = 16,
  parameter int LANES    = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 bank_i,
  input  logic                                 busy_i,
  input  logic [2:0][$clog2(NREG)-1:0]         rd_addr_i,
  output logic [2:0][DW-1:0]                   rd_data_o,
  input  logic                                 wr_en_i,
  input  logic [$clog2(NREG)-1:0]              wr_addr_i,
  input  logic [DW-1:0]                        wr_data_i,
  input  logic                                 aux_wr_en_i,
  input  logic [DW-1:0]                        aux_data_i,
  output logic [DW-1:0]                        aux_data_o,
  input  logic [$clog2(NCTX/LANES)-1:0]        grp_i,
  input  logic                                 rest_en_i,
  output logic [LANES-1:0][DW-1:0]             ctx_rd_o,
  input  logic [LANES-1:0][DW-1:0]             ctx_wr_i
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] regs_q [2*NREG];
  logic [DW-1:0] aux_q;
  logic [AW-1:0] grp_base;
  logic          wr_ok;

  assign grp_base = AW'(CTX_BASE) + AW'(grp_i) * AW'(LANES);
  assign wr_ok    = wr_en_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2*NREG; i++) regs_q[i] <= '0;
      aux_q <= '0;
    end else begin
      if (wr_ok) regs_q[{bank_i, wr_addr_i}] <= wr_data_i;
      if (aux_wr_en_i && !busy_i) aux_q <= aux_data_i;
      if (rest_en_i) begin
        for (int l = 0; l < LANES; l++)
          regs_q[{bank_i, grp_base + AW'(l)}] <= ctx_wr_i[l];
      end
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_rd
    assign rd_data_o[p] = (wr_ok && wr_addr_i == rd_addr_i[p]) ? wr_data_i
                                                               : regs_q[{bank_i, rd_addr_i[p]}];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) ctx_rd_o[l] = regs_q[{bank_i, grp_base + AW'(l)}];
  end

  assign aux_data_o = aux_q;

  a_r9_aux_held_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(aux_q));
endmodule

// File: rtl/rf_ctx_bank.sv
`timescale 1ns/1ps
module rf_ctx_bank #(
  parameter int DW     = 32,
  parameter int NREG   = 32,
  parameter int NPARAM = 14,
  parameter int NCTX   = 16,
  parameter int LANES  = 4,
  parameter int DEPTH  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(NREG)-1:0] rd_addr0_i,
  input  logic [$clog2(NREG)-1:0] rd_addr1_i,
  input  logic [$clog2(NREG)-1:0] rd_addr2_i,
  output logic [DW-1:0]           rd_data0_o,
  output logic [DW-1:0]           rd_data1_o,
  output logic [DW-1:0]           rd_data2_o,
  input  logic                    wr_en_i,
  input  logic [$clog2(NREG)-1:0] wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic                    aux_wr_en_i,
  input  logic [DW-1:0]           aux_data_i,
  output logic [DW-1:0]           aux_data_o,
  input  logic                    call_i,
  input  logic                    ret_i,
  input  logic                    irq_i,
  input  logic                    eret_i,
  output logic                    stall_o,
  output logic                    exc_mode_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  localparam int CTX_BASE = NPARAM;
  localparam int GROUPS   = NCTX / LANES;
  localparam int GW       = $clog2(GROUPS);
  localparam int FW       = $clog2(DEPTH);

  logic                      busy, save_en, rest_en, bank;
  logic [GW-1:0]             grp;
  logic [FW-1:0]             frame;
  logic [LANES-1:0][DW-1:0]  ctx_out, ctx_in;
  logic [2:0][DW-1:0]        rd_data;

  rf_seq_ctrl #(.DEPTH(DEPTH), .GROUPS(GROUPS)) u_ctrl (
    .clk_i, .rst_ni, .call_i, .ret_i, .irq_i, .eret_i,
    .busy_o(busy), .save_en_o(save_en), .rest_en_o(rest_en),
    .grp_o(grp), .frame_o(frame), .bank_o(bank), .ovf_o, .unf_o
  );

  rf_reg_banks #(.DW(DW), .NREG(NREG), .CTX_BASE(CTX_BASE), .NCTX(NCTX), .LANES(LANES)) u_banks (
    .clk_i, .rst_ni, .bank_i(bank), .busy_i(busy),
    .rd_addr_i({rd_addr2_i, rd_addr1_i, rd_addr0_i}), .rd_data_o(rd_data),
    .wr_en_i, .wr_addr_i, .wr_data_i, .aux_wr_en_i, .aux_data_i, .aux_data_o,
    .grp_i(grp), .rest_en_i(rest_en), .ctx_rd_o(ctx_out), .ctx_wr_i(ctx_in)
  );

  rf_save_stack #(.DW(DW), .DEPTH(DEPTH), .NCTX(NCTX), .LANES(LANES)) u_stack (
    .clk_i, .wr_en_i(save_en), .frame_i(frame), .grp_i(grp),
    .wdata_i(ctx_out), .rdata_o(ctx_in)
  );

  assign rd_data0_o = rd_data[0];
  assign rd_data1_o = rd_data[1];
  assign rd_data2_o = rd_data[2];
  assign stall_o    = busy;
  assign exc_mode_o = bank;

  a_r12_irq_beats_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && call_i && !stall_o && !exc_mode_o) |=> (!stall_o && exc_mode_o));
  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: tb/rf_ctx_bank_bench.sv
`timescale 1ns/1ps
module rf_ctx_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ra0 = '0, ra1 = '0, ra2 = '0, wa = '0;
  logic [31:0] rd0, rd1, rd2, wd = '0, aux_d = '0, aux_q;
  logic        we = 1'b0, aux_we = 1'b0, call = 1'b0, ret = 1'b0, irq = 1'b0, eret = 1'b0;
  logic        stall, exc, ovf, unf;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;  // 20 ns period

  rf_ctx_bank u_rf_ctx_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr0_i(ra0), .rd_addr1_i(ra1), .rd_addr2_i(ra2),
    .rd_data0_o(rd0), .rd_data1_o(rd1), .rd_data2_o(rd2),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .aux_wr_en_i(aux_we), .aux_data_i(aux_d), .aux_data_o(aux_q),
    .call_i(call), .ret_i(ret), .irq_i(irq), .eret_i(eret),
    .stall_o(stall), .exc_mode_o(exc), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; wa = a; wd = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    ra0 = a;
    #0.1;
    chk(tag, rd0, exp);
  endtask

  task automatic do_call();
    call = 1'b1; step(); call = 1'b0;
    repeat (4) step();
  endtask

  task automatic do_ret();
    ret = 1'b1; step(); ret = 1'b0;
    repeat (4) step();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) rd_chk("R1 reg zero", 5'(i), 32'h0);
    chk("R1 stall", {31'b0, stall}, 32'h0);
    chk("R1 exc", {31'b0, exc}, 32'h0);
    chk("R1 ovf", {31'b0, ovf}, 32'h0);
    chk("R1 unf", {31'b0, unf}, 32'h0);
    chk("R1 aux", aux_q, 32'h0);
  endtask

  task automatic t_rw();
    for (int i = 0; i < 32; i++) wr(5'(i), 32'h1000_0000 | i);
    ra0 = 5'd3; ra1 = 5'd17; ra2 = 5'd31; #0.1;
    chk("R2 port0", rd0, 32'h1000_0003);
    chk("R2 port1", rd1, 32'h1000_0011);
    chk("R2 port2", rd2, 32'h1000_001F);
    ra0 = 5'd31; ra1 = 5'd0; ra2 = 5'd14; #0.1;
    chk("R2 port0 b", rd0, 32'h1000_001F);
    chk("R2 port1 b", rd1, 32'h1000_0000);
    chk("R2 port2 b", rd2, 32'h1000_000E);
  endtask

  task automatic t_bypass();
    ra0 = 5'd6; ra1 = 5'd5;
    we = 1'b1; wa = 5'd5; wd = 32'hDEAD_0005;
    #0.1;
    chk("R3 bypass same cycle", rd1, 32'hDEAD_0005);
    chk("R3 other port old", rd0, 32'h1000_0006);
    step();
    we = 1'b0; #0.1;
    chk("R3 after edge", rd1, 32'hDEAD_0005);
  endtask

  task automatic t_aux();
    aux_we = 1'b1; aux_d = 32'hA5A5_0001;
    #0.1;
    chk("R4 aux not yet", aux_q, 32'h0);
    step();
    aux_we = 1'b0;
    chk("R4 aux loaded", aux_q, 32'hA5A5_0001);
  endtask

  task automatic t_call_ret();
    call = 1'b1; step(); call = 1'b0;
    we = 1'b1; wa = 5'd3; wd = 32'h0000_0BAD;
    aux_we = 1'b1; aux_d = 32'h0000_0BAD;
    for (int c = 0; c < 4; c++) begin
      chk("R5 stall during save", {31'b0, stall}, 32'h1);
      step();
    end
    we = 1'b0; aux_we = 1'b0;
    chk("R5 stall drops", {31'b0, stall}, 32'h0);
    rd_chk("R9 write ignored", 5'd3, 32'h1000_0003);
    chk("R9 aux ignored", aux_q, 32'hA5A5_0001);
    rd_chk("R5 ctx kept 14", 5'd14, 32'h1000_000E);
    rd_chk("R5 ctx kept 29", 5'd29, 32'h1000_001D);
    for (int i = 0; i < 32; i++) wr(5'(i), 32'h2000_0000 | i);
    ret = 1'b1; step(); ret = 1'b0;
    for (int c = 0; c < 4; c++) begin
      chk("R6 stall during restore", {31'b0, stall}, 32'h1);
      step();
    end
    chk("R6 stall drops", {31'b0, stall}, 32'h0);
    for (int i = 0; i < 32; i++)
      rd_chk("R6 restore map", 5'(i), (i >= 14 && i <= 29) ? (32'h1000_0000 | i) : (32'h2000_0000 | i));
  endtask

  task automatic t_nest();
    for (int lvl = 0; lvl < 8; lvl++) begin
      for (int c = 14; c < 30; c++) wr(5'(c), 32'h3000_0000 | (lvl << 8) | c);
      do_call();
    end
    call = 1'b1; step(); call = 1'b0;
    chk("R8 ovf pulse", {31'b0, ovf}, 32'h1);
    chk("R8 no stall on ovf", {31'b0, stall}, 32'h0);
    step();
    chk("R8 ovf one cycle", {31'b0, ovf}, 32'h0);
    rd_chk("R8 regs unchanged", 5'd14, 32'h3000_070E);
    for (int lvl = 7; lvl >= 0; lvl--) begin
      if (lvl != 7) for (int c = 14; c < 30; c++) wr(5'(c), 32'h0);
      do_ret();
      rd_chk("R7 lifo r14", 5'd14, 32'h3000_0000 | (lvl << 8) | 14);
      rd_chk("R7 lifo r21", 5'd21, 32'h3000_0000 | (lvl << 8) | 21);
      rd_chk("R7 lifo r29", 5'd29, 32'h3000_0000 | (lvl << 8) | 29);
    end
    ret = 1'b1; step(); ret = 1'b0;
    chk("R8 unf pulse", {31'b0, unf}, 32'h1);
    chk("R8 no stall on unf", {31'b0, stall}, 32'h0);
    step();
    chk("R8 unf one cycle", {31'b0, unf}, 32'h0);
    rd_chk("R8 regs kept on unf", 5'd20, 32'h3000_0014);
  endtask

  task automatic t_irq();
    irq = 1'b1; step(); irq = 1'b0;
    chk("R10 exc entered", {31'b0, exc}, 32'h1);
    rd_chk("R10 exc bank empty", 5'd2, 32'h0);
    wr(5'd2, 32'h0000_00E2);
    rd_chk("R10 exc bank write", 5'd2, 32'h0000_00E2);
    chk("R4 aux shared", aux_q, 32'hA5A5_0001);
    irq = 1'b1; step(); irq = 1'b0;
    eret = 1'b1; step(); eret = 1'b0;
    chk("R10 eret leaves", {31'b0, exc}, 32'h0);
    rd_chk("R10 normal bank intact", 5'd2, 32'h2000_0002);
    rd_chk("R10 normal ctx intact", 5'd20, 32'h3000_0014);
    step(); step();
    chk("R11 nested irq dropped", {31'b0, exc}, 32'h0);
  endtask

  task automatic t_irq_during_save();
    call = 1'b1; step(); call = 1'b0;
    irq = 1'b1; step(); irq = 1'b0;
    chk("R11 stall held", {31'b0, stall}, 32'h1);
    chk("R11 irq blocked", {31'b0, exc}, 32'h0);
    for (int c = 0; c < 2; c++) begin
      step();
      chk("R11 stall held", {31'b0, stall}, 32'h1);
      chk("R11 irq blocked", {31'b0, exc}, 32'h0);
    end
    step();
    chk("R11 stall ends", {31'b0, stall}, 32'h0);
    chk("R11 not yet taken", {31'b0, exc}, 32'h0);
    step();
    chk("R11 taken after seq", {31'b0, exc}, 32'h1);
    eret = 1'b1; step(); eret = 1'b0;
    for (int c = 14; c < 30; c++) wr(5'(c), 32'h0);
    do_ret();
    rd_chk("R11 frame saved", 5'd20, 32'h3000_0014);
  endtask

  task automatic t_irq_call();
    irq = 1'b1; call = 1'b1; step(); irq = 1'b0; call = 1'b0;
    chk("R12 no stall", {31'b0, stall}, 32'h0);
    chk("R12 irq taken", {31'b0, exc}, 32'h1);
    eret = 1'b1; step(); eret = 1'b0;
    ret = 1'b1; step(); ret = 1'b0;
    chk("R12 call dropped", {31'b0, unf}, 32'h1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_rw();
    t_bypass();
    t_aux();
    t_call_ret();
    t_nest();
    t_irq();
    t_irq_during_save();
    t_irq_call();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule